// File: doc/BRIEF.md
# Serial Control-Register Slave with Calibration Readback

This block is a two-wire, I2C-compatible slave that fronts a small bank of byte-wide control registers for an RF front end. It sits on a system clock at least sixteen times faster than the serial clock. It samples both bus lines through a short synchronizer and finds their edges. It drives the data line only as an open-drain pull-down enable. Its 7-bit device address is a fixed five-bit prefix plus two bits taken from a three-state board strap that has already been decoded.

A host writes by sending the device address, a register pointer and any number of data bytes, and the pointer advances after each byte. To read, the host first writes the pointer, then issues a repeated START with the read bit set and clocks bytes out until it declines to acknowledge. Three locations are read-only: a readback byte from a 13-entry calibration table, and two status bytes supplied from outside. The host selects a table entry by writing its index to the table-index register, and that write copies the entry into the readback register. A write to the lowest fractional-divider byte also fires a one-cycle strobe that starts an external tuning sequence.

Top module: `i2c_cal_regslave`

## Requirements
- R1: The slave responds only to address bytes whose upper seven bits equal {5'b11000, addr_sel[1:0]}. addr_sel is 2'b00 for a low strap, 2'b01 for an open strap and 2'b10 for a high strap, which gives write/read address bytes C0/C1, C2/C3 and C4/C5.
- R2: Each byte takes nine serial clocks: eight bits, MSB first, then an acknowledge bit. The slave acknowledges by asserting sda_oe from the SCL fall after bit eight to the SCL fall after the ninth clock, and sda_oe changes only while SCL is low.
- R3: SDA falling while SCL is high is a START and SDA rising while SCL is high is a STOP, in any state. A repeated START restarts the address phase.
- R4: A write carries the address byte (R/W=0), a pointer byte and then data bytes. Every one of these bytes is acknowledged, each data byte goes to the register at the pointer, and the pointer then advances by one.
- R5: A read returns bytes from the pointer onward after a repeated START with R/W=1, advancing the pointer after each byte. It continues while the host acknowledges, and after a host NACK the slave releases SDA until the next START.
- R6: Register 0x0E keeps only the low four bits of a written byte. Each write to it loads register 0x10 with table[a] = (29*a + 0x3B) mod 256 when a < 13, and with 0x00 when a is 13 to 15.
- R7: Registers 0x10, 0x11 and 0x12 are read-only. Writes to them are acknowledged and have no effect, 0x11 returns vas_status and 0x12 returns gen_status.
- R8: Each data byte written to register 0x04 produces exactly one tune_start pulse of one clock. No other register fires the pulse.
- R9: After reset, all writable registers (0x00 to 0x0F, 0x13, 0x14) and register 0x10 read 0x00, sda_oe is low and tune_start is low.
- R10: After an address byte that does not match, the slave does not acknowledge it or any byte that follows. It changes no register until the next START.
- R11: Addresses 0x15 to 0xFF read as 0x00, and writes to them are acknowledged and discarded.
- R12: The register pointer wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 2 | Decoded address strap, forms device address bits [1:0] |
| vas_status | input | 8 | Autoselect status returned at register 0x11 |
| gen_status | input | 8 | General status returned at register 0x12 |
| sda_oe | output | 1 | Pull SDA low when high |
| tune_start | output | 1 | One-cycle strobe on a write to register 0x04 |
| cfg_regs | output | 168 | Register byte i on bits [8i+7:8i]; read-only slots are zero |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except to signal START or STOP, it never issues STOP while the slave is pulling SDA low, and it holds each SCL phase for at least sixteen system clocks, so the synchronizer never merges an SCL edge with an SDA edge. The bench master keeps to this. Each SCL phase lasts sixteen clocks, data moves a quarter period after SCL falls, and every STOP comes after an acknowledge phase has ended or after a host NACK. The host samples SDA in the middle of the high phase, so the slave's synchronizer delay of a few clocks never lands on a sampling point.

// File: rtl/i2crb_pkg.sv
`timescale 1ns/1ps
package i2crb_pkg;

    localparam int BYTE_W       = 8;
    localparam int REG_COUNT    = 21;          // locations 0x00 .. 0x14
    localparam int ROM_DEPTH    = 13;
    localparam int ROM_IDX_W    = 4;
    localparam logic [4:0] DEV_PREFIX = 5'b11000;

    localparam logic [7:0] TRIG_ADDR  = 8'h04;
    localparam logic [7:0] ROMA_ADDR  = 8'h0E;
    localparam logic [7:0] ROMRB_ADDR = 8'h10;
    localparam logic [7:0] VAS_ADDR   = 8'h11;
    localparam logic [7:0] GEN_ADDR   = 8'h12;
    localparam logic [7:0] ROMA_MASK  = 8'h0F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD
    } bus_state_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    // Locations that hold host-written state.
    function automatic logic reg_is_writable(input logic [7:0] a);
        return (a <= 8'h0F) || (a == 8'h13) || (a == 8'h14);
    endfunction

    // Calibration table contents, computed rather than listed.
    function automatic logic [7:0] rom_value(input logic [ROM_IDX_W-1:0] a);
        logic [7:0] a8;
        a8 = {{(8-ROM_IDX_W){1'b0}}, a};
        if (int'(a) < ROM_DEPTH)
            return 8'(a8 * 8'd29 + 8'd59);
        return 8'h00;
    endfunction

endpackage

// File: rtl/i2crb_sync.sv
`timescale 1ns/1ps
module i2crb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2crb_engine.sv
`timescale 1ns/1ps
module i2crb_engine
    import i2crb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [1:0] dev_sel,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_ptr,
    output reg_wr_t    wr_o,
    output logic       sda_oe
);
    bus_state_t state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic [7:0] ptr;
    logic       rw;
    logic       mack;
    logic       start_det;
    logic       stop_det;

    assign start_det = scl & sda_fall;
    assign stop_det  = scl & sda_rise;
    assign rd_ptr    = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            sda_oe  <= 1'b0;
            wr_o    <= '0;
        end else begin
            wr_o.en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < 4'd8)
                        shreg <= {shreg[6:0], sda};
                    if (bit_cnt == 4'd8)
                        mack <= ~sda;
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (scl_fall) begin
                    if (bit_cnt == 4'd8) begin
                        // eight bits in: acknowledge phase begins
                        case (state)
                            ST_ADDR: begin
                                if (shreg[7:1] == {DEV_PREFIX, dev_sel}) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                end else begin
                                    state   <= ST_IDLE;
                                    bit_cnt <= '0;
                                end
                            end
                            ST_PTR: begin
                                sda_oe <= 1'b1;
                                ptr    <= shreg;
                            end
                            ST_WR: begin
                                sda_oe <= 1'b1;
                                wr_o   <= '{en: 1'b1, addr: ptr, data: shreg};
                                ptr    <= ptr + 8'd1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (bit_cnt == 4'd9) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                        case (state)
                            ST_ADDR: begin
                                if (rw) begin
                                    state  <= ST_RD;
                                    txreg  <= rd_data;
                                    ptr    <= ptr + 8'd1;
                                    sda_oe <= ~rd_data[7];
                                end else begin
                                    state <= ST_PTR;
                                end
                            end
                            ST_PTR: state <= ST_WR;
                            ST_RD: begin
                                if (mack) begin
                                    txreg  <= rd_data;
                                    ptr    <= ptr + 8'd1;
                                    sda_oe <= ~rd_data[7];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            default: ;
                        endcase
                    end else if (state == ST_RD && bit_cnt != 4'd0) begin
                        sda_oe <= ~txreg[6];
                        txreg  <= {txreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= 4'd9); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R10

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl) || $past(start_det) || $past(stop_det))); // R2

    AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (rst)
        wr_o.en |-> sda_oe); // R4
endmodule

// File: rtl/i2crb_regbank.sv
`timescale 1ns/1ps
module i2crb_regbank
    import i2crb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  reg_wr_t                   wr_i,
    input  logic [7:0]                rd_addr,
    input  logic [7:0]                vas_status,
    input  logic [7:0]                gen_status,
    output logic [7:0]                rd_data,
    output logic                      tune_start,
    output logic [REG_COUNT*BYTE_W-1:0] cfg_flat
);
    logic [7:0] rom_rb;

    for (genvar gi = 0; gi < REG_COUNT; gi++) begin : g_reg
        if (reg_is_writable(8'(gi))) begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_i.en && wr_i.addr == 8'(gi))
                    q <= (8'(gi) == ROMA_ADDR) ? (wr_i.data & ROMA_MASK) : wr_i.data;
            end
            assign cfg_flat[gi*BYTE_W +: BYTE_W] = q;
        end else begin : g_ro
            assign cfg_flat[gi*BYTE_W +: BYTE_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_rb     <= '0;
            tune_start <= 1'b0;
        end else begin
            tune_start <= wr_i.en && (wr_i.addr == TRIG_ADDR);
            if (wr_i.en && wr_i.addr == ROMA_ADDR)
                rom_rb <= rom_value(wr_i.data[ROM_IDX_W-1:0]);
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++)
            if (rd_addr == 8'(i))
                rd_data = cfg_flat[i*BYTE_W +: BYTE_W];
        if (rd_addr == ROMRB_ADDR) rd_data = rom_rb;
        if (rd_addr == VAS_ADDR)   rd_data = vas_status;
        if (rd_addr == GEN_ADDR)   rd_data = gen_status;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tune_start |=> !tune_start); // R8

    AST_RB_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_i.en && wr_i.addr != ROMA_ADDR) |=> $stable(rom_rb)); // R7
endmodule

// File: rtl/i2c_cal_regslave.sv
`timescale 1ns/1ps
module i2c_cal_regslave
    import i2crb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scl_in,
    input  logic                          sda_in,
    input  logic [1:0]                    addr_sel,
    input  logic [7:0]                    vas_status,
    input  logic [7:0]                    gen_status,
    output logic                          sda_oe,
    output logic                          tune_start,
    output logic [REG_COUNT*BYTE_W-1:0]   cfg_regs
);
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;

    logic [1:0] raw_lines, lvl, rise, fall;
    logic [7:0] rd_ptr, rd_data;
    reg_wr_t    wr;

    assign raw_lines = {sda_in, scl_in};

    for (genvar li = 0; li < 2; li++) begin : g_sync
        i2crb_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .din   (raw_lines[li]),
            .level (lvl[li]),
            .rise  (rise[li]),
            .fall  (fall[li])
        );
    end

    i2crb_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .scl      (lvl[LINE_SCL]),
        .scl_rise (rise[LINE_SCL]),
        .scl_fall (fall[LINE_SCL]),
        .sda      (lvl[LINE_SDA]),
        .sda_rise (rise[LINE_SDA]),
        .sda_fall (fall[LINE_SDA]),
        .dev_sel  (addr_sel),
        .rd_data  (rd_data),
        .rd_ptr   (rd_ptr),
        .wr_o     (wr),
        .sda_oe   (sda_oe)
    );

    i2crb_regbank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr),
        .rd_addr    (rd_ptr),
        .vas_status (vas_status),
        .gen_status (gen_status),
        .rd_data    (rd_data),
        .tune_start (tune_start),
        .cfg_flat   (cfg_regs)
    );
endmodule

// File: tb/i2c_cal_regslave_bench.sv
`timescale 1ns/1ps
module i2c_cal_regslave_bench;
    localparam int T = 80;   // quarter SCL period: 8 system clocks

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl = 1'b1;
    logic         sda_m_low = 1'b0;
    logic         sda_line;
    logic [1:0]   addr_sel = 2'b00;
    logic [7:0]   vas_status = 8'h5C;
    logic [7:0]   gen_status = 8'hA3;
    logic         sda_oe;
    logic         tune_start;
    logic [167:0] cfg_regs;

    int n_chk = 0, n_fail = 0, pulses = 0, wide = 0;
    bit done = 1'b0;
    logic ts_prev = 1'b0;

    logic [7:0] m_reg [0:255];
    logic [7:0] m_rb;
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];

    always #5 clk = ~clk;
    assign sda_line = ~(sda_m_low | sda_oe);

    i2c_cal_regslave u_i2c_cal_regslave (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .addr_sel(addr_sel), .vas_status(vas_status), .gen_status(gen_status),
        .sda_oe(sda_oe), .tune_start(tune_start), .cfg_regs(cfg_regs)
    );

    always @(negedge clk) begin
        if (tune_start) pulses++;
        if (tune_start && ts_prev) wide++;
        ts_prev = tune_start;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_exp(input int a);
        return (a < 13) ? 8'((29 * a + 59) % 256) : 8'h00;
    endfunction

    function automatic bit writable(input int a);
        return (a <= 15) || (a == 8'h13) || (a == 8'h14);
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        if (writable(a)) m_reg[a] = (a == 8'h0E) ? (d & 8'h0F) : d;
        if (a == 8'h0E) m_rb = rom_exp(int'(d & 8'h0F));
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a == 8'h10) return m_rb;
        if (a == 8'h11) return vas_status;
        if (a == 8'h12) return gen_status;
        if (writable(a)) return m_reg[a];
        return 8'h00;
    endfunction

    task automatic bus_start;
        sda_m_low = 1'b0; #T; scl = 1'b1; #T; sda_m_low = 1'b1; #T; scl = 1'b0; #T;
    endtask

    task automatic bus_stop;
        sda_m_low = 1'b1; #T; scl = 1'b1; #T; sda_m_low = 1'b0; #(2*T);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m_low = ~b[i]; #T; scl = 1'b1; #(2*T); scl = 1'b0; #T;
        end
        sda_m_low = 1'b0; #T; scl = 1'b1; #T;
        acked = (sda_line == 1'b0);
        #T; scl = 1'b0; #T;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            #T; scl = 1'b1; #T; b = {b[6:0], sda_line}; #T; scl = 1'b0; #T;
        end
        sda_m_low = mack; #T; scl = 1'b1; #(2*T); scl = 1'b0; #T; sda_m_low = 1'b0;
    endtask

    // write n bytes of wbuf starting at ptr; all_ack reports every acknowledge
    task automatic wr_burst(input logic [7:0] dev, input logic [7:0] ptr, input int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        bus_start;
        send_byte(dev, a); all_ack &= a;
        send_byte(ptr, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ack &= a;
        end
        bus_stop;
    endtask

    task automatic rd_burst(input logic [7:0] ptr, input int n);
        bit a;
        bus_start;
        send_byte(8'hC2, a);
        check(a, "R5 pointer phase address ack", int'(a), 1);
        send_byte(ptr, a);
        bus_start;                      // repeated START
        send_byte(8'hC3, a);
        check(a, "R3 repeated START read address ack", int'(a), 1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop;
        check(sda_oe == 1'b0, "R5 SDA released after NACK and STOP", int'(sda_oe), 0);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run finished)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [7:0] expv;
        for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
        m_rb = 8'h00;
        repeat (6) @(posedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R9: reset state
        check(sda_oe == 1'b0, "R9 sda_oe after reset", int'(sda_oe), 0);
        check(tune_start == 1'b0, "R9 tune_start after reset", int'(tune_start), 0);
        check(cfg_regs == '0, "R9 registers after reset", $countones(cfg_regs), 0);

        // R1 and R10: address match sweep over all strap settings
        for (int s = 0; s < 3; s++) begin
            addr_sel = 2'(s);
            for (int d = 0; d < 4; d++) begin
                logic [7:0] dev;
                dev = 8'hC0 + 8'(2 * d);
                bus_start;
                send_byte(dev, ok);
                bus_stop;
                check(ok == (d == s), "R1 address ack for strap", int'(ok), int'(d == s));
            end
        end
        addr_sel = 2'b01;

        // R9: register 0x10 reads zero before any table access
        rd_burst(8'h10, 1);
        check(rbuf[0] == 8'h00, "R9 readback register after reset", rbuf[0], 0);

        // R4 and R8: burst write across the whole bank
        pulses = 0;
        for (int i = 0; i < 21; i++) wbuf[i] = 8'(i * 7 + 17);
        wr_burst(8'hC2, 8'h00, 21, ok);
        for (int i = 0; i < 21; i++) model_write(i, wbuf[i]);
        check(ok, "R4 every byte of burst acked", int'(ok), 1);
        check(pulses == 1, "R8 one strobe for burst over 0x04", pulses, 1);
        for (int i = 0; i < 21; i++) begin
            expv = (writable(i)) ? m_reg[i] : 8'h00;
            check(cfg_regs[i*8 +: 8] == expv, "R4 register contents after burst", cfg_regs[i*8 +: 8], expv);
        end

        // R5, R7, R11: sequential read past the end of the bank
        rd_burst(8'h00, 24);
        for (int i = 0; i < 24; i++)
            check(rbuf[i] == exp_read(i), (i > 8'h14) ? "R11 nonexistent reads zero" :
                  (i >= 8'h10 && i <= 8'h12) ? "R7 read-only value" : "R5 sequential read",
                  rbuf[i], exp_read(i));

        // R6: table sweep through the index register
        for (int a = 0; a < 16; a++) begin
            wbuf[0] = 8'hA0 | 8'(a);
            wr_burst(8'hC2, 8'h0E, 1, ok);
            model_write(8'h0E, wbuf[0]);
            rd_burst(8'h0E, 3);
            check(rbuf[0] == 8'(a), "R6 index register keeps low nibble", rbuf[0], a);
            check(rbuf[2] == rom_exp(a), "R6 table byte in readback", rbuf[2], rom_exp(a));
        end

        // R7: writes to read-only locations are discarded
        vas_status = 8'h3E;
        gen_status = 8'hC9;
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
        wr_burst(8'hC2, 8'h10, 3, ok);
        check(ok, "R7 write to read-only acked", int'(ok), 1);
        rd_burst(8'h10, 3);
        for (int i = 0; i < 3; i++)
            check(rbuf[i] == exp_read(16 + i), "R7 read-only unchanged", rbuf[i], exp_read(16 + i));

        // R12 and R11: pointer wrap, writes to missing addresses dropped
        wbuf[0] = 8'h5A; wbuf[1] = 8'h6B; wbuf[2] = 8'h7C;
        wr_burst(8'hC2, 8'hFE, 3, ok);
        model_write(0, 8'h7C);
        check(ok, "R11 write to nonexistent acked", int'(ok), 1);
        rd_burst(8'hFF, 2);
        check(rbuf[0] == 8'h00, "R11 address 0xFF reads zero", rbuf[0], 0);
        check(rbuf[1] == 8'h7C, "R12 pointer wrapped to 0x00", rbuf[1], 8'h7C);

        // R8: single writes to the trigger register
        pulses = 0;
        wbuf[0] = 8'h11;
        wr_burst(8'hC2, 8'h04, 1, ok);
        wr_burst(8'hC2, 8'h04, 1, ok);
        model_write(4, 8'h11);
        check(pulses == 2, "R8 strobe per write to 0x04", pulses, 2);
        check(wide == 0, "R8 strobe lasts one cycle", wide, 0);
        pulses = 0;
        wbuf[0] = 8'h22;
        wr_burst(8'hC2, 8'h05, 1, ok);
        model_write(5, 8'h22);
        check(pulses == 0, "R8 no strobe for other register", pulses, 0);

        // R10: foreign address is ignored, bytes after it too
        wbuf[0] = 8'h99;
        wr_burst(8'hC4, 8'h01, 1, ok);
        check(!ok, "R10 foreign transaction not acked", int'(ok), 0);
        check(cfg_regs[15:8] == m_reg[1], "R10 register untouched", cfg_regs[15:8], m_reg[1]);
        rd_burst(8'h01, 1);
        check(rbuf[0] == m_reg[1], "R10 register reads unchanged", rbuf[0], m_reg[1]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule